// File: doc/BRIEF.md
# Flash Erase Status Flag Controller

This block produces the status byte that a host polls while an embedded flash array is being erased or programmed. It receives already-decoded command strobes (sector erase, bulk erase, byte program, reset command), a per-sector write-protect mask, and a pass/fail indication from the array model. It reports a toggle bit, a sticky error flag and an erase-window flag, together with a busy output and a mask of sectors that have failed.

A sector erase first opens an accumulation window, measured in clock cycles. A second sector erase that arrives inside this window adds its sector and closes the window at once. When the window closes, the selected sectors that are not protected are erased one at a time, lowest index first. If every selected sector is protected, the block toggles for a short abort period and then returns to idle without erasing anything. A bulk erase targets every unprotected sector and skips the window. The array model's failure indication is sampled at the end of each sector erase or byte program. A failure sets the error flag and marks that sector in the bad-sector mask.

Top module: `erase_status_ctrl`

## Requirements
- R1: After a synchronous reset, `busy_q` is 0, `bad_mask_q` is 0 and `status_q` is 8'h08: the window flag (bit 3) is 1 and all other bits are 0.
- R2: Each `status_rd` pulse taken while the block is busy inverts the toggle bit (bit 6 of `status_q`). A read taken while idle leaves the toggle bit unchanged.
- R3: A sector erase accepted in idle raises `busy_q` and clears the window flag (bit 3) on the next cycle. Bit 3 stays 0 for WIN_CYC = CLK_MHZ*WINDOW_US cycles, then returns to 1, and the erase proceeds.
- R4: A second sector erase inside the window sets bit 3 to 1 on the next cycle and adds its sector to the erase set. Each erased sector takes ERASE_CYC cycles.
- R5: If every sector in the erase set is protected, the block stays busy and toggles on reads for ABORT_CYC = CLK_MHZ*ABORT_US cycles. It then goes idle with the error flag and the bad-sector mask unchanged.
- R6: A bulk erase while every sector is protected is ignored: `busy_q` stays 0 and `status_q` is unchanged.
- R7: A bulk erase erases every unprotected sector in sequence, ERASE_CYC cycles each, without opening a window. Bit 3 stays 1 throughout.
- R8: When `fail_in` is high at the end of a sector erase or byte program, the error flag (bit 5) becomes 1 and that sector's bit in `bad_mask_q` is set.
- R9: The error flag is sticky through later successful operations and is cleared only by `cmd_reset`, which leaves `bad_mask_q` as it was. Bits in `bad_mask_q` never clear except on `rst`.
- R10: A program or erase that completes without failure leaves the error flag at 0 when it was 0.
- R11: A byte program to an unprotected sector is busy for PROG_CYC cycles. A byte program to a protected sector is ignored. In idle, sector erase takes priority over bulk erase, and bulk erase over program.
- R12: While busy, program and bulk-erase strobes are ignored. A bulk erase during the window neither closes the window nor adds sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sector_erase | input | 1 | Sector erase command strobe |
| cmd_sector | input | $clog2(NUM_SECTORS) | Target sector for sector erase and program |
| cmd_bulk_erase | input | 1 | Bulk erase command strobe |
| cmd_program | input | 1 | Byte program command strobe |
| cmd_reset | input | 1 | Reset command strobe; clears the error flag |
| prot_mask | input | NUM_SECTORS | Per-sector protection, 1 = protected |
| fail_in | input | 1 | Failure indication from the array model |
| status_rd | input | 1 | Status read strobe |
| status_q | output | 8 | Status byte: bit 6 toggle, bit 5 error, bit 3 window flag |
| busy_q | output | 1 | High while an operation or abort is in progress |
| bad_mask_q | output | NUM_SECTORS | Sectors that have recorded a failure |

## Verification
The erase path is exercised with four kinds of request:
- a lone sector erase, which shows the window flag opening and then timing out;
- two sector erases in quick succession, where the early window close and the doubled busy length separate accumulation from a single erase;
- a sector erase aimed only at a protected sector, which must toggle and then end with no error and no mask change, telling abort apart from a real erase;
- a bulk erase with part of the array protected and the failure input held high, whose resulting bad-sector mask shows exactly which sectors were visited.

Byte programs with and without failure, a reset command, and strobes sent while the block is busy separate the sticky error flag from the permanent bad-sector mask, and show which commands are ignored.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WINDOW,
    ST_ERASE,
    ST_PROG,
    ST_ABORT
  } esc_state_e;

  localparam int TGL_BIT = 6;
  localparam int ERR_BIT = 5;
  localparam int TMR_BIT = 3;
endpackage

// File: rtl/esc_countdown.sv
module esc_countdown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (en && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // a running count only moves downward by one per enabled cycle
  assert_cnt_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && en && !zero) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/esc_first_set.sv
module esc_first_set #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/erase_status_ctrl.sv
module erase_status_ctrl
  import esc_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int CLK_MHZ     = 100,
  parameter int WINDOW_US   = 100,
  parameter int ABORT_US    = 100,
  parameter int ERASE_CYC   = 2000,
  parameter int PROG_CYC    = 200
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_sector_erase,
  input  logic [$clog2(NUM_SECTORS)-1:0] cmd_sector,
  input  logic                           cmd_bulk_erase,
  input  logic                           cmd_program,
  input  logic                           cmd_reset,
  input  logic [NUM_SECTORS-1:0]         prot_mask,
  input  logic                           fail_in,
  input  logic                           status_rd,
  output logic [7:0]                     status_q,
  output logic                           busy_q,
  output logic [NUM_SECTORS-1:0]         bad_mask_q
);
  localparam int NS        = NUM_SECTORS;
  localparam int SW        = $clog2(NS);
  localparam int WIN_CYC   = CLK_MHZ * WINDOW_US;
  localparam int ABORT_CYC = CLK_MHZ * ABORT_US;
  localparam int MAX_AB    = (WIN_CYC > ABORT_CYC) ? WIN_CYC : ABORT_CYC;
  localparam int MAX_EP    = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_MAX   = (MAX_AB > MAX_EP) ? MAX_AB : MAX_EP;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam logic [NS-1:0] ONE = {{(NS-1){1'b0}}, 1'b1};

  esc_state_e    state_q, state_d;
  logic [NS-1:0] sel_q, sel_d;
  logic [NS-1:0] rem_q, rem_d;
  logic [SW-1:0] prog_sec_q, prog_sec_d;
  logic          tgl_q, err_q, tmr_q, tmr_d;
  logic [NS-1:0] bad_q;
  logic [NS-1:0] sec_oh, cur_oh, fail_oh, eff_set;
  logic [SW-1:0] cur_idx;
  logic          cur_any;
  logic          fail_evt;
  logic          cnt_load, cnt_en, cnt_zero;
  logic [CW-1:0] cnt_val;

  assign sec_oh = ONE << cmd_sector;
  assign cur_oh = ONE << cur_idx;

  esc_first_set #(.N(NS), .IW(SW)) u_pick (
    .vec (rem_q),
    .idx (cur_idx),
    .any (cur_any)
  );

  esc_countdown #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .en       (cnt_en),
    .zero     (cnt_zero)
  );

  always_comb begin
    state_d    = state_q;
    sel_d      = sel_q;
    rem_d      = rem_q;
    prog_sec_d = prog_sec_q;
    tmr_d      = tmr_q;
    cnt_load   = 1'b0;
    cnt_val    = '0;
    cnt_en     = 1'b0;
    fail_evt   = 1'b0;
    fail_oh    = '0;
    eff_set    = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_sector_erase) begin
          sel_d    = sec_oh;
          state_d  = ST_WINDOW;
          tmr_d    = 1'b0;
          cnt_load = 1'b1;
          cnt_val  = CW'(WIN_CYC - 1);
        end else if (cmd_bulk_erase && !(&prot_mask)) begin
          rem_d    = ~prot_mask;
          state_d  = ST_ERASE;
          tmr_d    = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = CW'(ERASE_CYC - 1);
        end else if (cmd_program && !prot_mask[cmd_sector]) begin
          prog_sec_d = cmd_sector;
          state_d    = ST_PROG;
          cnt_load   = 1'b1;
          cnt_val    = CW'(PROG_CYC - 1);
        end
      end
      ST_WINDOW: begin
        cnt_en = 1'b1;
        if (cmd_sector_erase || cnt_zero) begin
          tmr_d   = 1'b1;
          eff_set = (sel_q | (cmd_sector_erase ? sec_oh : '0)) & ~prot_mask;
          cnt_load = 1'b1;
          if (eff_set == '0) begin
            state_d = ST_ABORT;
            cnt_val = CW'(ABORT_CYC - 1);
          end else begin
            rem_d   = eff_set;
            state_d = ST_ERASE;
            cnt_val = CW'(ERASE_CYC - 1);
          end
        end
      end
      ST_ERASE: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          fail_evt = fail_in;
          fail_oh  = fail_in ? cur_oh : '0;
          rem_d    = rem_q & ~cur_oh;
          if (rem_d == '0) begin
            state_d = ST_IDLE;
          end else begin
            cnt_load = 1'b1;
            cnt_val  = CW'(ERASE_CYC - 1);
          end
        end
      end
      ST_PROG: begin
        cnt_en = 1'b1;
        if (cnt_zero) begin
          fail_evt = fail_in;
          fail_oh  = fail_in ? (ONE << prog_sec_q) : '0;
          state_d  = ST_IDLE;
        end
      end
      ST_ABORT: begin
        cnt_en = 1'b1;
        if (cnt_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      rem_q      <= '0;
      prog_sec_q <= '0;
      busy_q     <= 1'b0;
      tmr_q      <= 1'b1;
      tgl_q      <= 1'b0;
      err_q      <= 1'b0;
      bad_q      <= '0;
    end else begin
      state_q    <= state_d;
      sel_q      <= sel_d;
      rem_q      <= rem_d;
      prog_sec_q <= prog_sec_d;
      busy_q     <= (state_d != ST_IDLE);
      tmr_q      <= tmr_d;
      if (status_rd && (state_q != ST_IDLE)) tgl_q <= ~tgl_q;
      if (fail_evt)       err_q <= 1'b1;
      else if (cmd_reset) err_q <= 1'b0;
      bad_q      <= bad_q | fail_oh;
    end
  end

  always_comb begin
    status_q          = 8'h00;
    status_q[TGL_BIT] = tgl_q;
    status_q[ERR_BIT] = err_q;
    status_q[TMR_BIT] = tmr_q;
  end

  assign bad_mask_q = bad_q;

  // ---------------- assertions ----------------
  assert_tgl_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_q) |=> $stable(tgl_q));

  assert_tgl_flip_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && status_rd) |=> (tgl_q != $past(tgl_q)));

  assert_window_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (!tmr_q) |-> busy_q);

  assert_abort_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ABORT && !cmd_reset) |=> ($stable(err_q) && $stable(bad_mask_q)));

  assert_bulk_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && cmd_bulk_erase && (&prot_mask) && !cmd_sector_erase && !cmd_program)
      |=> !busy_q);

  assert_erase_target_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERASE) |-> (cur_any && !prot_mask[cur_idx]));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_q && !cmd_reset) |=> err_q);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_reset && !fail_evt) |=> !err_q);

  assert_bad_mono_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(bad_mask_q) & ~bad_mask_q) == '0));

  assert_prog_prot_R11: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && cmd_program && prot_mask[cmd_sector] && !cmd_sector_erase && !cmd_bulk_erase)
      |=> !busy_q);
endmodule

// File: tb/erase_status_ctrl_bench.sv
module erase_status_ctrl_bench;
  localparam int NS = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_sector_erase = 1'b0;
  logic [SW-1:0] cmd_sector = '0;
  logic          cmd_bulk_erase = 1'b0;
  logic          cmd_program = 1'b0;
  logic          cmd_reset = 1'b0;
  logic [NS-1:0] prot_mask = '0;
  logic          fail_in = 1'b0;
  logic          status_rd = 1'b0;
  logic [7:0]    status_q;
  logic          busy_q;
  logic [NS-1:0] bad_mask_q;

  always #5 clk = ~clk;

  erase_status_ctrl #(
    .NUM_SECTORS(NS), .CLK_MHZ(1), .WINDOW_US(100), .ABORT_US(60),
    .ERASE_CYC(20), .PROG_CYC(8)
  ) u_erase_status_ctrl (
    .clk(clk), .rst(rst), .cmd_sector_erase(cmd_sector_erase), .cmd_sector(cmd_sector),
    .cmd_bulk_erase(cmd_bulk_erase), .cmd_program(cmd_program), .cmd_reset(cmd_reset),
    .prot_mask(prot_mask), .fail_in(fail_in), .status_rd(status_rd),
    .status_q(status_q), .busy_q(busy_q), .bad_mask_q(bad_mask_q)
  );

  typedef struct {
    string tag;
    int    field; // 0 busy, 1 toggle, 2 error, 3 window flag, 4 bad mask, 5 whole status
    int    exp;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic int observe(int f);
    case (f)
      0: return int'(busy_q);
      1: return int'(status_q[6]);
      2: return int'(status_q[5]);
      3: return int'(status_q[3]);
      4: return int'(bad_mask_q);
      default: return int'(status_q);
    endcase
  endfunction

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      int act;
      it  = sbq.pop_front();
      act = observe(it.field);
      n_cmp++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s field%0d actual=%0h expected=%0h", it.tag, it.field, act, it.exp);
      end
    end
  end

  task automatic expect_f(string tag, int f, int v);
    item_t it;
    it.tag = tag; it.field = f; it.exp = v;
    sbq.push_back(it);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_se(int s);
    cmd_sector_erase = 1'b1; cmd_sector = SW'(s); tick(); cmd_sector_erase = 1'b0;
  endtask

  task automatic pulse_prog(int s);
    cmd_program = 1'b1; cmd_sector = SW'(s); tick(); cmd_program = 1'b0;
  endtask

  task automatic pulse_bulk();
    cmd_bulk_erase = 1'b1; tick(); cmd_bulk_erase = 1'b0;
  endtask

  task automatic pulse_rst_cmd();
    cmd_reset = 1'b1; tick(); cmd_reset = 1'b0;
  endtask

  task automatic rd();
    status_rd = 1'b1; tick(); status_rd = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy_q; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    expect_f("R1 busy", 0, 0);
    expect_f("R1 status", 5, 'h08);
    expect_f("R1 bad", 4, 0);

    // R6 bulk erase with everything protected
    prot_mask = 8'hFF;
    pulse_bulk();
    expect_f("R6 busy", 0, 0);
    tick();
    expect_f("R6 status", 5, 'h08);

    // R11 program to protected sector ignored
    pulse_prog(2);
    expect_f("R11 protected busy", 0, 0);
    prot_mask = 8'h00;
    pulse_prog(2);                 // edge E
    expect_f("R11 busy", 0, 1);
    rd();                           // E+2
    expect_f("R2 toggle busy", 1, 1);
    tick(4);                        // E+6
    expect_f("R11 busy mid", 0, 1);
    tick(4);                        // E+10
    expect_f("R11 idle", 0, 0);
    expect_f("R10 err", 2, 0);
    rd();
    expect_f("R2 toggle idle hold", 1, 1);

    // R3 single sector erase with window timeout
    pulse_se(3);
    expect_f("R3 window low", 3, 0);
    expect_f("R3 busy", 0, 1);
    tick(49);
    expect_f("R3 window mid", 3, 0);
    tick(60);                       // E+110
    expect_f("R3 window closed", 3, 1);
    expect_f("R3 erasing", 0, 1);
    wait_idle();
    expect_f("R10 err after erase", 2, 0);
    expect_f("R10 bad after erase", 4, 0);

    // R4 accumulation of a second sector
    pulse_se(1);
    tick(10);
    pulse_se(4);                    // edge F
    expect_f("R4 window closed early", 3, 1);
    tick(29);                       // F+30
    expect_f("R4 still erasing", 0, 1);
    tick(15);                       // F+45
    expect_f("R4 done", 0, 0);

    // R5 protected-only erase aborts
    prot_mask = 8'h04;
    pulse_se(2);                    // edge E
    expect_f("R5 busy", 0, 1);
    tick(109);                      // E+110, aborting
    expect_f("R5 abort busy", 0, 1);
    rd();
    expect_f("R5 toggle in abort", 1, 0);
    tick(64);                       // E+175
    expect_f("R5 idle", 0, 0);
    expect_f("R5 err", 2, 0);
    expect_f("R5 bad", 4, 0);

    // R7 / R8 bulk erase with failures on unprotected sectors
    prot_mask = 8'hF0;
    fail_in = 1'b1;
    pulse_bulk();                   // edge B
    expect_f("R7 busy", 0, 1);
    expect_f("R7 window flag", 3, 1);
    tick(69);                       // B+70
    expect_f("R7 still erasing", 0, 1);
    tick(15);                       // B+85
    expect_f("R7 done", 0, 0);
    expect_f("R8 err", 2, 1);
    expect_f("R8 bad", 4, 'h0F);
    fail_in = 1'b0;

    // R9 sticky error, reset command keeps bad mask
    prot_mask = 8'h00;
    pulse_prog(5);
    wait_idle();
    expect_f("R9 err sticky", 2, 1);
    pulse_rst_cmd();
    expect_f("R9 err cleared", 2, 0);
    expect_f("R9 bad kept", 4, 'h0F);

    // R8 program failure marks its sector
    fail_in = 1'b1;
    pulse_prog(6);
    wait_idle();
    fail_in = 1'b0;
    expect_f("R8 prog err", 2, 1);
    expect_f("R8 prog bad", 4, 'h4F);
    pulse_rst_cmd();

    // R12 bulk erase during the window is ignored
    pulse_se(0);                    // edge E
    tick(5);
    pulse_bulk();
    expect_f("R12 window open", 3, 0);
    tick(83);                       // E+90
    expect_f("R12 window still open", 3, 0);
    tick(35);                       // E+125
    expect_f("R12 only one sector", 0, 0);
    expect_f("R12 bad unchanged", 4, 'h4F);

    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule